// File: doc/BRIEF.md
# Soft-Start and Fault Sequencer for a Buck Controller

This block is the digital supervisor of a synchronous buck controller. Four power-on-reset flags come in: supply, enable pin, current-limit pin and frequency pin. Once all four are released, the block raises a soft-start ramp code. The ramp stands in for the soft-start capacitor, as an up/down counter that moves one code per clock in either direction. The block also derives the regulation target from that ramp. It decides when the gate drivers may switch, and it handles the three protection comparators: over-current, under-voltage and over-voltage.

Over-current is handled in hiccup fashion. The first qualified event switches the drivers off and discharges the ramp to zero, and a retry ramp then starts. If over-current returns during a retry, the drivers stop at once, but the ramp climbs on to a retry ceiling before it discharges. The third failing retry latches the block off. Under-voltage is armed only after soft-start completes. Over-voltage is watched through every active phase. Both latch the block off after a qualification delay counted in clocks. A latch is cleared only by a power-on reset.

Top module: `rampGuard`

## Requirements
- R1: While any of the four reset-release inputs is low, `stateCode` is 0 (idle), `rampCode` is 0, `driveEn` and `ssDone` are 0 and `faultCause` is 0. This holds from every state, including latched, so a reset drop clears a latch.
- R2: With all four released, idle moves to soft-start (`stateCode` 1) on the next clock and `driveEn` goes high. `rampCode` then rises by one per clock.
- R3: `targetCode` is 0 while `rampCode` is at or below SS_OFFSET. Above that it equals `rampCode` minus SS_OFFSET, and it is capped at REF = SS_END minus SS_OFFSET.
- R4: `rampCode` never exceeds SS_END. One clock after the ramp reaches SS_END in soft-start, `stateCode` becomes 2 (run) and `ssDone` goes to 1, and the ramp then holds.
- R5: `uvFlag` has no effect outside run. In run, UV_DLY consecutive high samples latch the block: `stateCode` 5, `faultCause` 2, `driveEn` 0.
- R6: In soft-start, run, discharge and retry, OV_DLY consecutive high samples of `ovFlag` latch the block with `faultCause` 3. A shorter burst has no effect.
- R7: `ocFlag` counts only while `upperOn` is high. An over-current event needs OC_DLY consecutive qualifying samples.
- R8: An over-current event in soft-start or run moves to discharge (`stateCode` 3) with `driveEn` 0. The ramp then falls by one per clock, and one clock after it reaches 0 a retry ramp starts (`stateCode` 4) with `driveEn` 1.
- R9: An over-current event during a retry ramp drops `driveEn` on the next clock. The ramp keeps rising to RETRY_TOP, then discharge begins.
- R10: An over-current event on the MAX_RETRY-th retry ramp latches the block with `faultCause` 1. A retry that reaches SS_END without a fault returns to run and restarts the retry count.
- R11: When several latching faults qualify on the same clock, over-voltage wins over under-voltage, and under-voltage wins over over-current.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rstN | input | 1 | asynchronous active-low reset |
| porSupply | input | 1 | supply reset released |
| porEnable | input | 1 | enable-pin reset released |
| porCurSet | input | 1 | current-limit pin reset released |
| porFreq | input | 1 | frequency pin reset released |
| ocFlag | input | 1 | over-current comparator output |
| upperOn | input | 1 | upper switch currently on |
| uvFlag | input | 1 | feedback below half of reference |
| ovFlag | input | 1 | feedback above 130 % of reference |
| rampCode | output | RAMP_W | soft-start ramp code |
| targetCode | output | RAMP_W | regulation target derived from the ramp |
| ssDone | output | 1 | soft-start completed (run) |
| driveEn | output | 1 | gate drivers may switch |
| stateCode | output | 3 | 0 idle, 1 soft-start, 2 run, 3 discharge, 4 retry, 5 latched |
| faultCause | output | 2 | 0 none, 1 over-current, 2 under-voltage, 3 over-voltage |

## Verification
A wrong state or a stray retry count does not stay hidden. It shows on `stateCode`, `driveEn` or `rampCode` in the first clock where the design and the reference model disagree. A fault counter that is off by one shifts the latch edge by exactly one clock, and an error in the ramp direction or saturation shows as a code mismatch in the very next cycle. The retry ceiling and the retry count only appear after several hundred clocks of hiccup operation. The bench therefore holds the over-current condition through the whole sequence, up to the latch.

// File: rtl/rampGuardPkg.sv
package rampGuardPkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SOFT  = 3'd1,
    ST_RUN   = 3'd2,
    ST_DISCH = 3'd3,
    ST_RETRY = 3'd4,
    ST_LATCH = 3'd5
  } seqState_t;

  typedef enum logic [1:0] {
    CAUSE_NONE = 2'd0,
    CAUSE_OC   = 2'd1,
    CAUSE_UV   = 2'd2,
    CAUSE_OV   = 2'd3
  } faultCause_t;

  // strobes from control to datapath
  typedef struct packed {
    logic rampUp;
    logic rampDown;
    logic rampClear;
    logic armOc;
    logic armUv;
    logic armOv;
  } seqCmd_t;

endpackage

// File: rtl/holdQual.sv
module holdQual #(
  parameter int DLY = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic cond,
  output logic trip
);
  localparam int CW = $clog2(DLY + 1);
  localparam logic [CW-1:0] LAST = CW'(DLY - 1);

  logic [CW-1:0] cntQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          cntQ <= '0;
    else if (!cond)     cntQ <= '0;
    else if (cntQ != LAST) cntQ <= cntQ + 1'b1;
  end

  assign trip = cond && (cntQ == LAST);
endmodule

// File: rtl/rampGuardPath.sv
module rampGuardPath
  import rampGuardPkg::*;
#(
  parameter int RAMP_W    = 8,
  parameter int SS_OFFSET = 54,
  parameter int SS_END    = 126,
  parameter int RETRY_TOP = 120,
  parameter int OC_DLY    = 3,
  parameter int UV_DLY    = 5,
  parameter int OV_DLY    = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqCmd_t           cmd,
  input  logic              ocFlag,
  input  logic              upperOn,
  input  logic              uvFlag,
  input  logic              ovFlag,
  output logic [RAMP_W-1:0] rampCode,
  output logic [RAMP_W-1:0] targetCode,
  output logic              rampAtEnd,
  output logic              rampAtTop,
  output logic              rampZero,
  output logic              ocTrip,
  output logic              uvTrip,
  output logic              ovTrip
);
  localparam logic [RAMP_W-1:0] END_C = RAMP_W'(SS_END);
  localparam logic [RAMP_W-1:0] TOP_C = RAMP_W'(RETRY_TOP);
  localparam logic [RAMP_W-1:0] OFF_C = RAMP_W'(SS_OFFSET);
  localparam logic [RAMP_W-1:0] REF_C = RAMP_W'(SS_END - SS_OFFSET);

  logic [RAMP_W-1:0] rampQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                               rampQ <= '0;
    else if (cmd.rampClear)                  rampQ <= '0;
    else if (cmd.rampUp && rampQ < END_C)    rampQ <= rampQ + 1'b1;
    else if (cmd.rampDown && rampQ != '0)    rampQ <= rampQ - 1'b1;
  end

  assign rampCode  = rampQ;
  assign rampAtEnd = (rampQ >= END_C);
  assign rampAtTop = (rampQ >= TOP_C);
  assign rampZero  = (rampQ == '0);

  logic [RAMP_W-1:0] aboveOff;
  always_comb begin
    aboveOff = rampQ - OFF_C;
    if (rampQ <= OFF_C)        targetCode = '0;
    else if (aboveOff > REF_C) targetCode = REF_C;
    else                       targetCode = aboveOff;
  end

  // fault qualifiers: index 0 over-current, 1 under-voltage, 2 over-voltage
  logic [2:0] condVec;
  logic [2:0] tripVec;
  assign condVec = {ovFlag & cmd.armOv, uvFlag & cmd.armUv, ocFlag & upperOn & cmd.armOc};

  for (genvar i = 0; i < 3; i++) begin : g_qual
    localparam int D = (i == 0) ? OC_DLY : (i == 1) ? UV_DLY : OV_DLY;
    holdQual #(.DLY(D)) u_qual (
      .clk  (clk),
      .rstN (rstN),
      .cond (condVec[i]),
      .trip (tripVec[i])
    );
  end

  assign ocTrip = tripVec[0];
  assign uvTrip = tripVec[1];
  assign ovTrip = tripVec[2];

  // R4
  ramp_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    rampQ <= END_C);

  // R8
  ramp_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.rampDown && !cmd.rampClear && !cmd.rampUp && rampQ != '0) |=> (rampQ == $past(rampQ) - 1'b1));

  // R1
  ramp_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.rampClear |=> (rampQ == '0));
endmodule

// File: rtl/rampGuardCtrl.sv
module rampGuardCtrl
  import rampGuardPkg::*;
#(
  parameter int MAX_RETRY = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        porOk,
  input  logic        rampAtEnd,
  input  logic        rampAtTop,
  input  logic        rampZero,
  input  logic        ocTrip,
  input  logic        uvTrip,
  input  logic        ovTrip,
  output seqCmd_t     cmd,
  output logic        ssDone,
  output logic        driveEn,
  output logic [2:0]  stateCode,
  output logic [1:0]  faultCause
);
  localparam int RW = $clog2(MAX_RETRY + 1);
  localparam logic [RW-1:0] RMAX = RW'(MAX_RETRY);

  seqState_t   stateQ, stateD;
  faultCause_t causeQ, causeD;
  logic [RW-1:0] retryQ, retryD;
  logic pendQ, pendD;

  always_comb begin
    cmd    = '0;
    stateD = stateQ;
    causeD = causeQ;
    retryD = retryQ;
    pendD  = pendQ;
    if (!porOk) begin
      cmd.rampClear = 1'b1;
      stateD = ST_IDLE;
      causeD = CAUSE_NONE;
      retryD = '0;
      pendD  = 1'b0;
    end else begin
      unique case (stateQ)
        ST_IDLE: begin
          cmd.rampClear = 1'b1;
          stateD = ST_SOFT;
        end
        ST_SOFT: begin
          cmd.rampUp = !rampAtEnd;
          cmd.armOc  = 1'b1;
          cmd.armOv  = 1'b1;
          if (ovTrip) begin
            stateD = ST_LATCH; causeD = CAUSE_OV;
          end else if (ocTrip) begin
            stateD = ST_DISCH; retryD = '0;
          end else if (rampAtEnd) begin
            stateD = ST_RUN;
          end
        end
        ST_RUN: begin
          cmd.armOc = 1'b1;
          cmd.armUv = 1'b1;
          cmd.armOv = 1'b1;
          if (ovTrip) begin
            stateD = ST_LATCH; causeD = CAUSE_OV;
          end else if (uvTrip) begin
            stateD = ST_LATCH; causeD = CAUSE_UV;
          end else if (ocTrip) begin
            stateD = ST_DISCH; retryD = '0;
          end
        end
        ST_DISCH: begin
          cmd.rampDown = 1'b1;
          cmd.armOv    = 1'b1;
          if (ovTrip) begin
            stateD = ST_LATCH; causeD = CAUSE_OV;
          end else if (rampZero) begin
            stateD = ST_RETRY;
            retryD = retryQ + 1'b1;
            pendD  = 1'b0;
          end
        end
        ST_RETRY: begin
          cmd.rampUp = pendQ ? !rampAtTop : !rampAtEnd;
          cmd.armOc  = !pendQ;
          cmd.armOv  = 1'b1;
          if (ovTrip) begin
            stateD = ST_LATCH; causeD = CAUSE_OV; pendD = 1'b0;
          end else if (ocTrip) begin
            if (retryQ >= RMAX) begin
              stateD = ST_LATCH; causeD = CAUSE_OC;
            end else begin
              pendD = 1'b1;
            end
          end else if (pendQ && rampAtTop) begin
            stateD = ST_DISCH; pendD = 1'b0;
          end else if (!pendQ && rampAtEnd) begin
            stateD = ST_RUN; retryD = '0;
          end
        end
        ST_LATCH: begin
          cmd.rampClear = 1'b1;
          pendD = 1'b0;
        end
        default: begin
          cmd.rampClear = 1'b1;
          stateD = ST_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      causeQ <= CAUSE_NONE;
      retryQ <= '0;
      pendQ  <= 1'b0;
    end else begin
      stateQ <= stateD;
      causeQ <= causeD;
      retryQ <= retryD;
      pendQ  <= pendD;
    end
  end

  assign ssDone     = (stateQ == ST_RUN);
  assign driveEn    = (stateQ == ST_SOFT) || (stateQ == ST_RUN) || (stateQ == ST_RETRY && !pendQ);
  assign stateCode  = stateQ;
  assign faultCause = causeQ;

  // R1
  por_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !porOk |=> (stateQ == ST_IDLE && causeQ == CAUSE_NONE));

  // R10
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_LATCH && porOk) |=> (stateQ == ST_LATCH && $stable(causeQ)));

  // R10
  retry_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    retryQ <= RMAX);

  // R8
  disch_retry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_DISCH && porOk && rampZero && !ovTrip) |=> (stateQ == ST_RETRY && driveEn));

  // R6
  ov_latch_chk: assert property (@(posedge clk) disable iff (!rstN)
    (porOk && ovTrip) |=> (stateQ == ST_LATCH && causeQ == CAUSE_OV && !driveEn));
endmodule

// File: rtl/rampGuard.sv
module rampGuard
  import rampGuardPkg::*;
#(
  parameter int RAMP_W    = 8,
  parameter int SS_OFFSET = 54,
  parameter int SS_END    = 126,
  parameter int RETRY_TOP = 120,
  parameter int MAX_RETRY = 3,
  parameter int OC_DLY    = 3,
  parameter int UV_DLY    = 5,
  parameter int OV_DLY    = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              porSupply,
  input  logic              porEnable,
  input  logic              porCurSet,
  input  logic              porFreq,
  input  logic              ocFlag,
  input  logic              upperOn,
  input  logic              uvFlag,
  input  logic              ovFlag,
  output logic [RAMP_W-1:0] rampCode,
  output logic [RAMP_W-1:0] targetCode,
  output logic              ssDone,
  output logic              driveEn,
  output logic [2:0]        stateCode,
  output logic [1:0]        faultCause
);
  seqCmd_t cmd;
  logic porOk;
  logic rampAtEnd, rampAtTop, rampZero;
  logic ocTrip, uvTrip, ovTrip;

  assign porOk = porSupply & porEnable & porCurSet & porFreq;

  rampGuardCtrl #(.MAX_RETRY(MAX_RETRY)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .porOk      (porOk),
    .rampAtEnd  (rampAtEnd),
    .rampAtTop  (rampAtTop),
    .rampZero   (rampZero),
    .ocTrip     (ocTrip),
    .uvTrip     (uvTrip),
    .ovTrip     (ovTrip),
    .cmd        (cmd),
    .ssDone     (ssDone),
    .driveEn    (driveEn),
    .stateCode  (stateCode),
    .faultCause (faultCause)
  );

  rampGuardPath #(
    .RAMP_W    (RAMP_W),
    .SS_OFFSET (SS_OFFSET),
    .SS_END    (SS_END),
    .RETRY_TOP (RETRY_TOP),
    .OC_DLY    (OC_DLY),
    .UV_DLY    (UV_DLY),
    .OV_DLY    (OV_DLY)
  ) u_path (
    .clk        (clk),
    .rstN       (rstN),
    .cmd        (cmd),
    .ocFlag     (ocFlag),
    .upperOn    (upperOn),
    .uvFlag     (uvFlag),
    .ovFlag     (ovFlag),
    .rampCode   (rampCode),
    .targetCode (targetCode),
    .rampAtEnd  (rampAtEnd),
    .rampAtTop  (rampAtTop),
    .rampZero   (rampZero),
    .ocTrip     (ocTrip),
    .uvTrip     (uvTrip),
    .ovTrip     (ovTrip)
  );
endmodule

// File: tb/rampGuard_bench.sv
`timescale 1ns/1ps
module rampGuard_bench;
  localparam int RW = 8, OFF = 54, ENDV = 126, TOP = 120, MAXR = 3;
  localparam int OCD = 3, UVD = 5, OVD = 5;
  localparam int REFV = ENDV - OFF;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic porSupply = 0, porEnable = 0, porCurSet = 0, porFreq = 0;
  logic ocFlag = 0, upperOn = 0, uvFlag = 0, ovFlag = 0;
  logic [RW-1:0] rampCode, targetCode;
  logic ssDone, driveEn;
  logic [2:0] stateCode;
  logic [1:0] faultCause;

  always #5 clk = ~clk;

  rampGuard u_rampGuard (
    .clk(clk), .rstN(rstN),
    .porSupply(porSupply), .porEnable(porEnable), .porCurSet(porCurSet), .porFreq(porFreq),
    .ocFlag(ocFlag), .upperOn(upperOn), .uvFlag(uvFlag), .ovFlag(ovFlag),
    .rampCode(rampCode), .targetCode(targetCode), .ssDone(ssDone), .driveEn(driveEn),
    .stateCode(stateCode), .faultCause(faultCause)
  );

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int mSt = 0, mRamp = 0, mRetry = 0, mPend = 0, mCause = 0;
  int mOc = 0, mUv = 0, mOv = 0;
  int nSt, nRamp, nRetry, nPend, nCause;
  bit por, cOc, cUv, cOv, tOc, tUv, tOv;

  task automatic latchTo(input int c);
    nSt = 5; nCause = c; nPend = 0;
  endtask

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mSt = 0; mRamp = 0; mRetry = 0; mPend = 0; mCause = 0;
      mOc = 0; mUv = 0; mOv = 0;
    end else begin
      por = porSupply && porEnable && porCurSet && porFreq;
      cOc = por && (mSt == 1 || mSt == 2 || (mSt == 4 && mPend == 0)) && ocFlag && upperOn;
      cUv = por && (mSt == 2) && uvFlag;
      cOv = por && (mSt >= 1 && mSt <= 4) && ovFlag;
      tOc = cOc && (mOc + 1 >= OCD);
      tUv = cUv && (mUv + 1 >= UVD);
      tOv = cOv && (mOv + 1 >= OVD);
      nSt = mSt; nRamp = mRamp; nRetry = mRetry; nPend = mPend; nCause = mCause;
      if (!por) begin
        nSt = 0; nRamp = 0; nRetry = 0; nPend = 0; nCause = 0;
      end else begin
        case (mSt)
          0: begin nSt = 1; nRamp = 0; end
          1: begin
            if (mRamp < ENDV) nRamp = mRamp + 1;
            if (tOv) latchTo(3);
            else if (tOc) begin nSt = 3; nRetry = 0; end
            else if (mRamp >= ENDV) nSt = 2;
          end
          2: begin
            if (tOv) latchTo(3);
            else if (tUv) latchTo(2);
            else if (tOc) begin nSt = 3; nRetry = 0; end
          end
          3: begin
            if (mRamp > 0) nRamp = mRamp - 1;
            if (tOv) latchTo(3);
            else if (mRamp == 0) begin nSt = 4; nRetry = mRetry + 1; nPend = 0; end
          end
          4: begin
            if (mPend != 0 ? (mRamp < TOP) : (mRamp < ENDV)) nRamp = mRamp + 1;
            if (tOv) latchTo(3);
            else if (tOc) begin
              if (mRetry >= MAXR) latchTo(1); else nPend = 1;
            end
            else if (mPend != 0 && mRamp >= TOP) begin nSt = 3; nPend = 0; end
            else if (mPend == 0 && mRamp >= ENDV) begin nSt = 2; nRetry = 0; end
          end
          default: begin nRamp = 0; nPend = 0; end
        endcase
      end
      mOc = cOc ? mOc + 1 : 0;
      mUv = cUv ? mUv + 1 : 0;
      mOv = cOv ? mOv + 1 : 0;
      mSt = nSt; mRamp = nRamp; mRetry = nRetry; mPend = nPend; mCause = nCause;
    end
  end

  function automatic int expTarget(input int r);
    if (r <= OFF) return 0;
    if (r - OFF > REFV) return REFV;
    return r - OFF;
  endfunction

  // per-cycle comparison, away from the edge
  always @(posedge clk) begin
    #3;
    if (!finished) begin
      chk(int'(stateCode) == mSt, "R10 model state", int'(stateCode), mSt);
      chk(int'(faultCause) == mCause, "R10 model cause", int'(faultCause), mCause);
      chk(int'(rampCode) == mRamp, "R2 model ramp", int'(rampCode), mRamp);
      chk(int'(targetCode) == expTarget(mRamp), "R3 model target", int'(targetCode), expTarget(mRamp));
      chk(int'(driveEn) == int'(mSt == 1 || mSt == 2 || (mSt == 4 && mPend == 0)),
          "R8 model driveEn", int'(driveEn), int'(mSt == 1 || mSt == 2 || (mSt == 4 && mPend == 0)));
      chk(int'(ssDone) == int'(mSt == 2), "R4 model ssDone", int'(ssDone), int'(mSt == 2));
    end
  end

  // ---------------- helpers ----------------
  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic porAll(input bit v);
    porSupply = v; porEnable = v; porCurSet = v; porFreq = v;
  endtask

  task automatic waitState(input int code, input int limit);
    for (int i = 0; i < limit; i++) begin
      if (int'(stateCode) == code) break;
      @(negedge clk);
    end
  endtask

  task automatic bootToRun();
    porAll(1'b0); cyc(2);
    porAll(1'b1);
    waitState(2, 400);
  endtask

  int maxPendRamp;
  int retryEntries;
  int prevState;

  initial begin
    cyc(3);
    rstN = 1'b1;
    cyc(2);
    // R1: reset state and partial release
    chk(stateCode == 3'd0 && rampCode == '0 && !driveEn && !ssDone, "R1 idle after reset", int'(stateCode), 0);
    porSupply = 1; porEnable = 1; porCurSet = 1;
    cyc(5);
    chk(stateCode == 3'd0 && !driveEn, "R1 three of four released", int'(stateCode), 0);

    // R2: full release
    porFreq = 1;
    cyc(1);
    chk(stateCode == 3'd1 && driveEn, "R2 soft-start entered", int'(stateCode), 1);
    cyc(10);
    chk(rampCode == 8'd10, "R2 ramp rate", int'(rampCode), 10);

    // R5: undervoltage ignored during soft-start
    uvFlag = 1; cyc(12); uvFlag = 0;
    chk(stateCode == 3'd1 && faultCause == 2'd0, "R5 uv ignored in soft-start", int'(stateCode), 1);

    // R3: target tracking
    while (rampCode < 8'd60) @(negedge clk);
    chk(targetCode == 8'd6, "R3 target offset", int'(targetCode), 6);
    waitState(2, 200);
    // R4
    chk(rampCode == 8'(ENDV) && ssDone, "R4 run with ramp at end", int'(rampCode), ENDV);
    chk(targetCode == 8'(REFV), "R3 target capped at reference", int'(targetCode), REFV);

    // R7: oc without upper switch, and short burst
    ocFlag = 1; upperOn = 0; cyc(10);
    chk(stateCode == 3'd2, "R7 oc ignored with upper off", int'(stateCode), 2);
    upperOn = 1; cyc(OCD - 1); ocFlag = 0;
    cyc(3);
    chk(stateCode == 3'd2, "R7 short oc burst ignored", int'(stateCode), 2);

    // R8: qualified oc in run
    ocFlag = 1; cyc(OCD); ocFlag = 0;
    chk(stateCode == 3'd3 && !driveEn, "R8 discharge on oc", int'(stateCode), 3);
    cyc(1);
    chk(rampCode == 8'(ENDV - 1), "R8 ramp falling", int'(rampCode), ENDV - 1);
    waitState(4, 300);
    chk(driveEn && rampCode == '0, "R8 retry ramp begins", int'(rampCode), 0);
    waitState(2, 300);
    chk(ssDone, "R10 clean retry back to run", int'(stateCode), 2);

    // R9 and R10: persistent over-current
    maxPendRamp = 0; retryEntries = 0; prevState = 2;
    ocFlag = 1; upperOn = 1;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (stateCode == 3'd4 && prevState != 4) retryEntries++;
      if (stateCode == 3'd4 && !driveEn && int'(rampCode) > maxPendRamp) maxPendRamp = int'(rampCode);
      prevState = int'(stateCode);
      if (stateCode == 3'd5) break;
    end
    ocFlag = 0;
    chk(maxPendRamp == TOP, "R9 retry ramp ceiling", maxPendRamp, TOP);
    chk(retryEntries == MAXR, "R10 retry count", retryEntries, MAXR);
    chk(stateCode == 3'd5 && faultCause == 2'd1 && !driveEn, "R10 oc latch", int'(faultCause), 1);
    cyc(20);
    chk(stateCode == 3'd5 && rampCode == '0, "R10 latch persists", int'(stateCode), 5);

    // R1: reset release clears latch
    porCurSet = 0; cyc(1);
    chk(stateCode == 3'd0 && faultCause == 2'd0, "R1 latch cleared by reset", int'(faultCause), 0);

    // R6: overvoltage
    porAll(1'b1); waitState(2, 400);
    ovFlag = 1; cyc(OVD - 1); ovFlag = 0; cyc(2);
    chk(stateCode == 3'd2, "R6 short ov ignored", int'(stateCode), 2);
    ovFlag = 1; cyc(OVD); ovFlag = 0;
    chk(stateCode == 3'd5 && faultCause == 2'd3, "R6 ov latch", int'(faultCause), 3);

    // R6 during soft-start
    porAll(1'b0); cyc(2); porAll(1'b1); cyc(20);
    ovFlag = 1; cyc(OVD); ovFlag = 0;
    chk(stateCode == 3'd5 && faultCause == 2'd3, "R6 ov latch in soft-start", int'(faultCause), 3);

    // R5: undervoltage in run
    bootToRun();
    uvFlag = 1; cyc(UVD); uvFlag = 0;
    chk(stateCode == 3'd5 && faultCause == 2'd2 && !driveEn, "R5 uv latch", int'(faultCause), 2);

    // R11: simultaneous qualification
    bootToRun();
    ovFlag = 1; uvFlag = 1; cyc(2);
    ocFlag = 1; upperOn = 1; cyc(OCD);
    ovFlag = 0; uvFlag = 0; ocFlag = 0;
    chk(stateCode == 3'd5 && faultCause == 2'd3, "R11 ov priority", int'(faultCause), 3);

    cyc(2);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    for (int i = 0; i < 150000; i++) @(posedge clk);
    if (!finished) begin
      finished = 1;
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end
endmodule